// File: doc/BRIEF.md
# Bit Timing Sample Point Generator

This block turns the system clock into a stream of time quanta. It walks through the segments of one nominal bit time: a single-quantum sync segment, then phase segment 1, then phase segment 2. At every quantum it compares the receive line with the level it held one quantum earlier. A change in level is an edge. A falling edge (recessive 1 to dominant 0) moves the bit grid. The bus is sampled on the last quantum of phase segment 1, and that level is presented as the bit value together with a one-clock strobe.

The quantum length, both phase segment lengths and the resynchronization jump width are static configuration inputs. An external frame layer tells the block when the bus is idle. While it is idle, a falling edge performs a hard synchronization. While it is busy, a falling edge performs a bounded resynchronization. The receive input is assumed to be synchronous to the clock already.

Top module: `bit_timing_gen`

## Requirements
- R1: `tq_pulse` is high for one clock once every `cfg_presc`+1 clocks. The field holds the quantum length minus one.
- R2: With no falling edge on the line, successive strobes are 3 + `cfg_ph1` + `cfg_ph2` quanta apart. `cfg_ph1` holds the phase-1 length minus one (1 to 16 quanta). `cfg_ph2` holds the phase-2 length minus one (1 to 8 quanta).
- R3: `bit_strobe` is high for exactly one clock, the clock after the final quantum of phase segment 1. `bit_value` then equals the level of `rx_in` at that quantum and holds until the next strobe.
- R4: A falling edge is a quantum whose `rx_in` is 0 while the previous quantum's level was 1. Rising edges never change the timing.
- R5: With `bus_idle` high, a falling edge in any segment makes that quantum the sync segment. The next sample is then taken `cfg_ph1`+1 quanta later.
- R6: With `bus_idle` low, a falling edge on quantum k of phase segment 1 (k counted from 1) lengthens that segment by min(k, `cfg_sjw`+1) quanta.
- R7: With `bus_idle` low, a falling edge in phase segment 2 shortens that segment by min(`cfg_sjw`+1, number of phase-2 quanta left after the edge quantum).
- R8: With `bus_idle` low, a falling edge during the sync segment leaves the timing unchanged.
- R9: During reset, `bit_strobe` is 0 and `bit_value` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_presc | input | PRESC_W | Clocks per quantum minus one |
| cfg_ph1 | input | PH1_W | Phase segment 1 length minus one |
| cfg_ph2 | input | PH2_W | Phase segment 2 length minus one |
| cfg_sjw | input | SJW_W | Jump width minus one |
| bus_idle | input | 1 | High while no frame is in progress (hard sync enabled) |
| rx_in | input | 1 | Receive line, 1 recessive, 0 dominant |
| tq_pulse | output | 1 | One-clock pulse per time quantum |
| bit_strobe | output | 1 | One-clock pulse per sampled bit |
| bit_value | output | 1 | Sampled bit level |

## Verification
Each configuration first holds the line steady so that the quantum length and the undisturbed bit period can be measured alone. Directed falling edges are then placed on chosen quanta: in the sync segment, at every reachable position of phase segment 1, and in phase segment 2. This separates the error-bounded lengthening from the early-bit shortening and from the edges that must do nothing. A hard sync, and a rising edge placed before each falling edge, show that only idle falls restart the grid and that rising levels are ignored. A random toggling phase then checks the sampled value against the level the bench recorded at the last quantum.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;
endpackage

// File: rtl/bt_tq_div.sv
// Time quantum divider: one tick every div_m1+1 clocks.
module bt_tq_div #(
    parameter int PRESC_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] div_m1,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt_d, cnt_q;

    // A larger-or-equal compare keeps a shrinking divisor from wrapping the count.
    always_comb begin
        tick  = (cnt_q >= div_m1);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bt_edge_det.sv
// Keeps the line level of the previous quantum and flags recessive-to-dominant changes.
module bt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    output logic fall
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = tick ? rx : lvl_q;
        fall  = tick & lvl_q & ~rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/bt_seg_seq.sv
// Segment sequencer: walks sync / phase 1 / phase 2, applies hard sync and
// bounded resynchronization, and produces the sample strobe.
module bt_seg_seq
    import bt_pkg::*;
#(
    parameter int PH1_W = 4,
    parameter int PH2_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fall,
    input  logic             idle,
    input  logic             rx,
    input  logic [PH1_W-1:0] cfg_ph1,
    input  logic [PH2_W-1:0] cfg_ph2,
    input  logic [SJW_W-1:0] cfg_sjw,
    output logic             strobe,
    output logic             value
);
    localparam int W_A   = (PH1_W > PH2_W) ? PH1_W : PH2_W;
    localparam int W_B   = (W_A > SJW_W) ? W_A : SJW_W;
    localparam int CNT_W = W_B + 2;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len1;
        logic [CNT_W-1:0] len2;
        logic             strobe;
        logic             value;
    } seq_t;

    seq_t d, q;

    logic [CNT_W-1:0] jump, nom1, nom2, err1, adj1, len1_n;
    logic [CNT_W-1:0] rem2, adj2, len2_n;

    always_comb begin
        jump   = CNT_W'(cfg_sjw) + ONE;
        nom1   = CNT_W'(cfg_ph1) + ONE;
        nom2   = CNT_W'(cfg_ph2) + ONE;
        // Late edge in phase 1: error counts the quanta since the sync segment.
        err1   = q.cnt + ONE;
        adj1   = (err1 < jump) ? err1 : jump;
        len1_n = (fall && !idle) ? q.len1 + adj1 : q.len1;
        // Early edge in phase 2: at most the quanta still left after this one.
        rem2   = (q.len2 > q.cnt) ? q.len2 - q.cnt - ONE : '0;
        adj2   = (rem2 < jump) ? rem2 : jump;
        len2_n = (fall && !idle) ? q.len2 - adj2 : q.len2;

        d        = q;
        d.strobe = 1'b0;
        if (tick) begin
            if (fall && idle) begin
                // Hard sync: this quantum is the sync segment.
                d.seg  = SEG_PH1;
                d.cnt  = '0;
                d.len1 = nom1;
                d.len2 = nom2;
            end else begin
                unique case (q.seg)
                    SEG_SYNC: begin
                        d.seg  = SEG_PH1;
                        d.cnt  = '0;
                        d.len1 = nom1;
                        d.len2 = nom2;
                    end
                    SEG_PH1: begin
                        d.len1 = len1_n;
                        if (q.cnt == len1_n - ONE) begin
                            d.seg    = SEG_PH2;
                            d.cnt    = '0;
                            d.strobe = 1'b1;
                            d.value  = rx;
                        end else begin
                            d.cnt = q.cnt + ONE;
                        end
                    end
                    SEG_PH2: begin
                        d.len2 = len2_n;
                        if (q.cnt >= len2_n - ONE) begin
                            d.seg = SEG_SYNC;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + ONE;
                        end
                    end
                    default: begin
                        d.seg = SEG_SYNC;
                        d.cnt = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.seg    <= SEG_SYNC;
            q.cnt    <= '0;
            q.len1   <= ONE;
            q.len2   <= ONE;
            q.strobe <= 1'b0;
            q.value  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign strobe = q.strobe;
    assign value  = q.value;
endmodule

// File: rtl/bit_timing_gen.sv
module bit_timing_gen #(
    parameter int PRESC_W = 6,
    parameter int PH1_W   = 4,
    parameter int PH2_W   = 3,
    parameter int SJW_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [PH1_W-1:0]   cfg_ph1,
    input  logic [PH2_W-1:0]   cfg_ph2,
    input  logic [SJW_W-1:0]   cfg_sjw,
    input  logic               bus_idle,
    input  logic               rx_in,
    output logic               tq_pulse,
    output logic               bit_strobe,
    output logic               bit_value
);
    logic fall;

    bt_tq_div #(.PRESC_W(PRESC_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_m1 (cfg_presc),
        .tick   (tq_pulse)
    );

    bt_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tq_pulse),
        .rx    (rx_in),
        .fall  (fall)
    );

    bt_seg_seq #(.PH1_W(PH1_W), .PH2_W(PH2_W), .SJW_W(SJW_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tq_pulse),
        .fall    (fall),
        .idle    (bus_idle),
        .rx      (rx_in),
        .cfg_ph1 (cfg_ph1),
        .cfg_ph2 (cfg_ph2),
        .cfg_sjw (cfg_sjw),
        .strobe  (bit_strobe),
        .value   (bit_value)
    );
endmodule

// File: rtl/bt_timing_chk.sv
module bt_timing_chk #(
    parameter int PRESC_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PRESC_W-1:0] cfg_presc,
    input logic               rx_in,
    input logic               tq_pulse,
    input logic               bit_strobe,
    input logic               bit_value
);
    // R1: after a quantum pulse the next clock is a pulse only for a one-clock quantum
    p_quantum_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tq_pulse |=> (!tq_pulse || cfg_presc == '0));

    // R3: a strobe always follows a quantum boundary
    p_strobe_on_quantum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> $past(tq_pulse));

    // R3: the strobe lasts a single clock
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> !bit_strobe);

    // R3: the presented bit is the line level at the sampling quantum
    p_value_is_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> (bit_value == $past(rx_in)));

    // R3: the bit value holds between strobes
    p_value_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_strobe |-> $stable(bit_value));
endmodule

bind bit_timing_gen bt_timing_chk #(.PRESC_W(PRESC_W)) u_timing_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_presc  (cfg_presc),
    .rx_in      (rx_in),
    .tq_pulse   (tq_pulse),
    .bit_strobe (bit_strobe),
    .bit_value  (bit_value)
);

// File: tb/test_bit_timing_gen.sv
`timescale 1ns/1ps
module test_bit_timing_gen;
    localparam int PRESC_W = 6;
    localparam int PH1_W   = 4;
    localparam int PH2_W   = 3;
    localparam int SJW_W   = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [PRESC_W-1:0] cfg_presc = '0;
    logic [PH1_W-1:0]   cfg_ph1 = '0;
    logic [PH2_W-1:0]   cfg_ph2 = '0;
    logic [SJW_W-1:0]   cfg_sjw = '0;
    logic               bus_idle = 1'b1;
    logic               rx_in = 1'b1;
    logic               tq_pulse, bit_strobe, bit_value;

    always #2 clk = ~clk;

    bit_timing_gen #(.PRESC_W(PRESC_W), .PH1_W(PH1_W), .PH2_W(PH2_W), .SJW_W(SJW_W))
    i_bit_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_presc(cfg_presc), .cfg_ph1(cfg_ph1),
        .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw), .bus_idle(bus_idle), .rx_in(rx_in),
        .tq_pulse(tq_pulse), .bit_strobe(bit_strobe), .bit_value(bit_value)
    );

    int   n_vec = 0, n_bad = 0;
    int   tick_no = 0, nstrobe = 0, strobe_tick = 0;
    logic strobe_val = 1'b1, tick_now = 1'b0, strobe_now = 1'b0;
    bit   done = 1'b0;

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Expected bit period in quanta with no falling edges (R2)
    function automatic int bit_quanta(input int p1, input int p2);
        return 3 + p1 + p2;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        strobe_now = bit_strobe;
        if (bit_strobe) begin
            nstrobe++;
            strobe_tick = tick_no;
            strobe_val  = bit_value;
        end
        tick_now = tq_pulse;
        if (tq_pulse) tick_no++;
    endtask

    task automatic run_to(input int t);
        int guard = 0;
        while (!(tick_now && tick_no == t) && guard < 6000) begin
            step();
            guard++;
        end
        if (guard >= 6000) check(1'b0, "quantum index reached", tick_no, t);
    endtask

    task automatic wait_strobe();
        int n0 = nstrobe;
        int guard = 0;
        while (nstrobe == n0 && guard < 6000) begin
            step();
            guard++;
        end
        if (guard >= 6000) check(1'b0, "strobe arrived", 0, 1);
    endtask

    task automatic run_cfg(input int p, input int a, input int b, input int s);
        int c, h, n, nb, l1, l2, jw, k, j, s3, t6, s4, xp;
        logic rec;
        l1 = a + 1; l2 = b + 1; jw = s + 1; nb = bit_quanta(a, b);
        cfg_presc = PRESC_W'(p); cfg_ph1 = PH1_W'(a);
        cfg_ph2 = PH2_W'(b);     cfg_sjw = SJW_W'(s);
        bus_idle = 1'b1; rx_in = 1'b1;

        // R1: clocks between quantum pulses
        step();
        while (!tick_now) step();
        c = 0;
        do begin step(); c++; end while (!tick_now);
        check(c == p + 1, "R1 quantum length", c, p + 1);

        // R5: hard sync on an idle falling edge
        h = tick_no + 2;
        run_to(h); rx_in = 1'b0;
        step(); bus_idle = 1'b0;
        wait_strobe();
        check(strobe_tick == h + l1, "R5 sample after hard sync", strobe_tick, h + l1);
        check(strobe_val == 1'b0, "R5 sampled level", int'(strobe_val), 0);

        // R4 rising edge in phase 2, R8 falling edge in the sync segment
        run_to(h + l1 + 1); rx_in = 1'b1;
        n = h + 1 + l1 + l2;
        run_to(n); rx_in = 1'b0;
        wait_strobe();
        check(strobe_tick == n + l1, "R8/R4 edges without timing effect", strobe_tick, n + l1);

        // R2: undisturbed bit period
        wait_strobe();
        check(strobe_tick == n + nb + l1, "R2 nominal bit period", strobe_tick, n + nb + l1);

        // R6: late edge in phase 1
        run_to(n + nb + l1 + 1); rx_in = 1'b1;
        s3 = n + 2 * nb;
        k  = $urandom_range(1, l1);
        run_to(s3 + k); rx_in = 1'b0;
        wait_strobe();
        t6 = s3 + l1 + min2(k, jw);
        check(strobe_tick == t6, "R6 phase 1 lengthening", strobe_tick, t6);

        // R7: early edge in phase 2
        s4 = t6 + l2 + 1;
        run_to(s4 + 1); rx_in = 1'b1;
        wait_strobe();
        j = $urandom_range(1, l2);
        run_to(s4 + l1 + j); rx_in = 1'b0;
        wait_strobe();
        xp = s4 + 2 * l1 + l2 + 1 - min2(jw, l2 - j);
        check(strobe_tick == xp, "R7 phase 2 shortening", strobe_tick, xp);

        // R3: random line activity, sampled value versus level at last quantum
        rec = rx_in;
        for (int i = 0; i < 500; i++) begin
            step();
            if (strobe_now)
                check(strobe_val == rec, "R3 sampled value", int'(strobe_val), int'(rec));
            if ($urandom_range(0, 7) == 0) rx_in = ~rx_in;
            if (tick_now) rec = rx_in;
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        // R9: reset state
        check(bit_strobe == 1'b0, "R9 strobe in reset", int'(bit_strobe), 0);
        check(bit_value == 1'b1, "R9 value in reset", int'(bit_value), 1);
        rst_n = 1'b1;

        run_cfg(0, 0, 0, 0);
        run_cfg(5, 15, 7, 3);
        run_cfg(0, 15, 0, 3);
        run_cfg(1, 0, 7, 0);
        run_cfg(2, 3, 1, 1);
        for (int r = 0; r < 16; r++)
            run_cfg($urandom_range(0, 5), $urandom_range(0, 15),
                    $urandom_range(0, 7), $urandom_range(0, 3));

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #700000;
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule